// File: doc/BRIEF.md
# Cartridge Wait-State Timing Unit

This block works out how many wait cycles a memory access costs and raises a ready strobe when those cycles have passed. It holds a 16-bit timing control word. The word is loaded through a single write strobe. Each access request gives an address, a width flag (16 or 32 bits) and a sequential flag. The unit takes a region index from the address and turns the control word, or a fixed timing for non-cartridge regions, into a wait count.

Three cartridge windows, each with a mirror region, and one cartridge SRAM region are programmable. Region 2 has a fixed cost and every other region costs nothing. A 32-bit access is charged as two 16-bit halves plus one cycle. The quoted count is always visible on `wait_cycles`. Once an access is accepted, a down-counter holds `busy` and pulses `ready` exactly that many clocks later. An access with no wait is acknowledged in the same cycle.

Top module: `cart_wait_timer`

## Requirements
- R1: The region index is address bits [27:24]. Regions 8/9 form window 0, 10/11 form window 1 and 12/13 form window 2. A window and its mirror always quote identical costs. Region 14 is SRAM.
- R2: The 16-bit non-sequential cost of a window comes from its 2-bit first-access field, at bits [3:2] (window 0), [6:5] (window 1) and [9:8] (window 2). Codes 0,1,2,3 give 4,3,2,8 cycles.
- R3: The 16-bit sequential cost of a window comes from its select bit: bit 4 (window 0), bit 7 (window 1), bit 10 (window 2). A clear bit gives 2, 4 or 8 cycles for windows 0, 1 and 2. A set bit gives 1 cycle.
- R4: SRAM uses bits [1:0] with the same 4,3,2,8 mapping, and its sequential and non-sequential 16-bit costs are equal.
- R5: For every region, a 32-bit non-sequential access costs n16+1+s16, and a 32-bit sequential access costs 2*s16+1.
- R6: Region 2 costs 2 cycles (16-bit, both kinds). All regions other than 2 and 8..14 cost 0 for 16-bit accesses, so 1 cycle for 32-bit accesses.
- R7: After reset the control word is 0x0000. This gives window 0 4/2, window 1 4/4, window 2 4/8 and SRAM 4/4 (non-sequential/sequential, 16-bit).
- R8: A request accepted while idle with cost N>0 raises `busy` from the next cycle. `ready` is high for exactly one cycle, N clocks after the request cycle, and `busy` is low again the cycle after that. A request with N=0 gets `ready` in its own cycle and `busy` is not set.
- R9: A request made while `busy` is high is ignored and does not move or add a `ready` pulse.
- R10: A control word write takes effect for requests in later cycles. It does not change the timing of an access already accepted.
- R11: Bits [15:11] of the control word, including the prefetch enable at bit 14, have no effect on any cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word value |
| req | input | 1 | Access request |
| req_addr | input | 32 | Access address |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| req_seq | input | 1 | 1 = sequential access |
| wait_cycles | output | 5 | Cost quoted for the presented request |
| ready | output | 1 | Access complete strobe |
| busy | output | 1 | An access is counting down |

## Verification
`wait_cycles` and a zero-wait `ready` are combinational, so the bench samples them 1 ns after driving the request on a falling edge, in the request cycle itself. For a cost N>0, the bench drops `req` and samples `ready` on each of the next N falling edges. It expects `ready` high only on the N-th and `busy` low one edge later, which places every strobe in its exact cycle. Control writes are applied on a falling edge and are expected to affect only requests from the following cycle onward.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

   localparam int unsigned CFG_W          = 16;
   localparam int unsigned NUM_WIN        = 3;
   localparam int unsigned REGION_FIXED   = 2;
   localparam int unsigned REGION_WIN_LO  = 8;
   localparam int unsigned REGION_SRAM    = 14;
   localparam int unsigned HALF_W         = 4;

   typedef logic [HALF_W-1:0] half_cost_t;

   typedef struct packed {
      half_cost_t nseq;
      half_cost_t seq;
   } pair_cost_t;

   // first-access code to wait cycles
   function automatic half_cost_t first_cost(input logic [1:0] code);
      case (code)
         2'd0:    first_cost = 4'd4;
         2'd1:    first_cost = 4'd3;
         2'd2:    first_cost = 4'd2;
         default: first_cost = 4'd8;
      endcase
   endfunction

   // sequential select to wait cycles; the slow value doubles per window
   function automatic half_cost_t burst_cost(input logic sel, input int unsigned win);
      burst_cost = sel ? 4'd1 : half_cost_t'(4'd2 << win);
   endfunction

endpackage

// File: rtl/cwt_cfg_reg.sv
module cwt_cfg_reg #(
   parameter int unsigned CFG_W     = 16,
   parameter logic [CFG_W-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= RESET_VAL;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/cwt_cost.sv
module cwt_cost
   import cwt_pkg::*;
#(
   parameter int unsigned REGION_W = 4,
   parameter int unsigned CNT_W    = 5
) (
   input  logic [CFG_W-1:0]    cfg,
   input  logic [REGION_W-1:0] region,
   input  logic                wide,
   input  logic                seq,
   output logic [CNT_W-1:0]    cost
);
   localparam int unsigned SUM_W = HALF_W + 1;

   generate
      if (CNT_W < SUM_W) begin : g_bad_cnt
         $error("CNT_W too small for the largest 32-bit cost");
      end
      if (REGION_W != 4) begin : g_bad_region
         $error("REGION_W must be 4");
      end
   endgenerate

   pair_cost_t win_cost [NUM_WIN];
   pair_cost_t sram_cost;
   pair_cost_t sel_cost;

   genvar w;
   generate
      for (w = 0; w < NUM_WIN; w++) begin : g_win
         localparam int unsigned FA_LSB  = 2 + 3 * w;
         localparam int unsigned SEQ_BIT = 4 + 3 * w;
         assign win_cost[w].nseq = first_cost(cfg[FA_LSB +: 2]);
         assign win_cost[w].seq  = burst_cost(cfg[SEQ_BIT], w);
      end
   endgenerate

   assign sram_cost.nseq = first_cost(cfg[1:0]);
   assign sram_cost.seq  = sram_cost.nseq;

   logic unused_cfg_hi;
   assign unused_cfg_hi = ^cfg[CFG_W-1:11];

   always_comb begin
      sel_cost = '0;
      case (region)
         4'd2:        sel_cost = '{nseq: 4'd2, seq: 4'd2};
         4'd8, 4'd9:  sel_cost = win_cost[0];
         4'd10, 4'd11: sel_cost = win_cost[1];
         4'd12, 4'd13: sel_cost = win_cost[2];
         4'd14:       sel_cost = sram_cost;
         default:     sel_cost = '0;
      endcase
   end

   logic [SUM_W-1:0] half_sel;
   logic [SUM_W-1:0] full_cost;

   always_comb begin
      half_sel = seq ? SUM_W'(sel_cost.seq) : SUM_W'(sel_cost.nseq);
      full_cost = SUM_W'(seq ? sel_cost.seq : sel_cost.nseq)
                + SUM_W'(sel_cost.seq) + SUM_W'(1);
      cost = wide ? CNT_W'(full_cost) : CNT_W'(half_sel);
   end
endmodule

// File: rtl/cwt_countdown.sv
module cwt_countdown #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             last
);
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n)               remain <= '0;
      else if (start && !busy)  remain <= load_val;
      else if (busy)            remain <= remain - CNT_W'(1);
   end

   assign busy = (remain != '0);
   assign last = (remain == CNT_W'(1));
endmodule

// File: rtl/cart_wait_timer.sv
module cart_wait_timer
   import cwt_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned REGION_LSB = 24,
   parameter int unsigned REGION_W   = 4,
   parameter int unsigned CNT_W      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [15:0]       cfg_wdata,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_wide,
   input  logic              req_seq,
   output logic [CNT_W-1:0]  wait_cycles,
   output logic              ready,
   output logic              busy
);
   generate
      if (REGION_LSB + REGION_W > ADDR_W) begin : g_bad_addr
         $error("region field lies outside the address");
      end
   endgenerate

   logic [CFG_W-1:0]    cfg_q;
   logic [REGION_W-1:0] region;
   logic                accept;
   logic                last;

   logic unused_addr;
   assign unused_addr = ^{req_addr[ADDR_W-1:REGION_LSB+REGION_W],
                          req_addr[REGION_LSB-1:0]};

   assign region = req_addr[REGION_LSB +: REGION_W];

   cwt_cfg_reg #(.CFG_W(CFG_W), .RESET_VAL('0)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
   );

   cwt_cost #(.REGION_W(REGION_W), .CNT_W(CNT_W)) u_cost (
      .cfg(cfg_q), .region(region), .wide(req_wide), .seq(req_seq),
      .cost(wait_cycles)
   );

   assign accept = req && !busy;

   cwt_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .start(accept && (wait_cycles != '0)),
      .load_val(wait_cycles),
      .busy(busy), .last(last)
   );

   assign ready = last || (accept && (wait_cycles == '0));
endmodule

// File: rtl/cwt_checker.sv
module cwt_checker #(
   parameter int unsigned CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req,
   input logic             req_wide,
   input logic             req_seq,
   input logic [CNT_W-1:0] wait_cycles,
   input logic             ready,
   input logic             busy
);
   logic [CNT_W-1:0] mdl;

   always_ff @(posedge clk) begin
      if (!rst_n)                                  mdl <= '0;
      else if (mdl != '0)                          mdl <= mdl - CNT_W'(1);
      else if (req && wait_cycles != '0)           mdl <= wait_cycles;
   end

   AST_ZERO_WAIT_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy && wait_cycles == '0) |-> ready); // R8

   AST_READY_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      (mdl != '0) |-> (ready == (mdl == CNT_W'(1)))); // R8

   AST_BUSY_TRACKS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      busy == (mdl != '0)); // R9

   AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ready) |=> !busy); // R8

   AST_WIDE_SEQ_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      (req && req_wide && req_seq) |-> wait_cycles[0]); // R5

   AST_COST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cycles <= CNT_W'(17)); // R5
endmodule

bind cart_wait_timer cwt_checker #(.CNT_W(CNT_W)) u_cwt_checker (
   .clk(clk), .rst_n(rst_n), .req(req), .req_wide(req_wide),
   .req_seq(req_seq), .wait_cycles(wait_cycles), .ready(ready), .busy(busy)
);

// File: tb/tb_cart_wait_timer.sv
`timescale 1ns/1ps
module tb_cart_wait_timer;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        cfg_we = 0;
   logic [15:0] cfg_wdata = '0;
   logic        req = 0;
   logic [31:0] req_addr = '0;
   logic        req_wide = 0;
   logic        req_seq = 0;
   logic [4:0]  wait_cycles;
   logic        ready;
   logic        busy;

   int checks = 0;
   int errors = 0;
   logic [15:0] shadow = '0;

   always #5 clk = ~clk;

   cart_wait_timer dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .req(req), .req_addr(req_addr), .req_wide(req_wide), .req_seq(req_seq),
      .wait_cycles(wait_cycles), .ready(ready), .busy(busy)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int fa(input logic [1:0] c);
      case (c)
         2'd0: return 4;
         2'd1: return 3;
         2'd2: return 2;
         default: return 8;
      endcase
   endfunction

   function automatic int exp_cost(input logic [15:0] w, input int region,
                                   input bit wide, input bit sq);
      int n, s;
      case (region)
         2:      begin n = 2; s = 2; end
         8, 9:   begin n = fa(w[3:2]); s = w[4]  ? 1 : 2; end
         10, 11: begin n = fa(w[6:5]); s = w[7]  ? 1 : 4; end
         12, 13: begin n = fa(w[9:8]); s = w[10] ? 1 : 8; end
         14:     begin n = fa(w[1:0]); s = n; end
         default: begin n = 0; s = 0; end
      endcase
      if (!wide) return sq ? s : n;
      return sq ? (2 * s + 1) : (n + 1 + s);
   endfunction

   task automatic write_cfg(input logic [15:0] v);
      @(negedge clk);
      cfg_we = 1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 0;
      shadow = v;
   endtask

   // quote only: present request, compare cost, then withdraw before the edge
   task automatic quote(input int region, input bit wide, input bit sq, input string tag);
      int e;
      @(negedge clk);
      req = 0; req_addr = {4'h0, 4'(region), 24'h00_1234}; req_wide = wide; req_seq = sq;
      #1;
      e = exp_cost(shadow, region, wide, sq);
      check(wait_cycles == 5'(e), tag, wait_cycles, e);
   endtask

   // full access with timing check
   task automatic access(input int region, input bit wide, input bit sq, input string tag);
      int e; bit ok;
      e = exp_cost(shadow, region, wide, sq);
      @(negedge clk);
      req = 1; req_addr = {4'h0, 4'(region), 24'h00_0010}; req_wide = wide; req_seq = sq;
      #1;
      check(wait_cycles == 5'(e), tag, wait_cycles, e);
      ok = (ready == (e == 0));
      for (int k = 1; k <= e; k++) begin
         @(negedge clk);
         req = 0;
         #1;
         if (ready != (k == e)) ok = 0;
         if (!busy) ok = 0;
      end
      @(negedge clk);
      req = 0;
      #1;
      if (busy || ready) ok = 0;
      check(ok, {tag, " timing R8"}, ok, 1);
   endtask

   task automatic t_reset;
      @(negedge clk); #1;
      check(!busy && !ready, "R7 idle after reset", busy, 0);
      quote(8, 0, 0, "R7 win0 nseq"); quote(8, 0, 1, "R7 win0 seq");
      quote(10, 0, 0, "R7 win1 nseq"); quote(10, 0, 1, "R7 win1 seq");
      quote(12, 0, 1, "R7 win2 seq"); quote(14, 0, 1, "R7 sram seq");
   endtask

   task automatic t_fields;
      for (int c = 0; c < 4; c++) begin
         write_cfg(16'((c << 2) | (((c + 1) % 4) << 5) | (((c + 2) % 4) << 8) | ((c + 3) % 4)));
         quote(8, 0, 0, "R2 win0 code"); quote(10, 0, 0, "R2 win1 code");
         quote(12, 0, 0, "R2 win2 code"); quote(14, 0, 0, "R4 sram nseq");
         quote(14, 0, 1, "R4 sram seq");
      end
      write_cfg(16'h0490);
      quote(9, 0, 1, "R3 win0 seq set"); quote(11, 0, 1, "R3 win1 seq set");
      quote(13, 0, 1, "R3 win2 seq set");
   endtask

   task automatic t_mirror_wide;
      int a, b;
      write_cfg(16'h0267);
      for (int r = 8; r < 14; r += 2) begin
         quote(r, 1, 0, "R1 window");
         a = wait_cycles;
         quote(r + 1, 1, 0, "R1 mirror");
         b = wait_cycles;
         check(a == b, "R1 mirror equal", b, a);
         quote(r, 1, 1, "R5 wide seq");
      end
      quote(14, 1, 0, "R5 sram wide");
      quote(2, 1, 0, "R6 fixed wide"); quote(2, 0, 1, "R6 fixed seq");
      quote(0, 0, 0, "R6 zero region"); quote(15, 1, 1, "R6 zero wide");
      quote(5, 0, 1, "R6 zero region 5");
   endtask

   task automatic t_high_bits;
      int a;
      write_cfg(16'h0123);
      quote(12, 1, 0, "R11 base"); a = wait_cycles;
      write_cfg(16'hF923);
      quote(12, 1, 0, "R11 high bits"); check(wait_cycles == 5'(a), "R11 unchanged", wait_cycles, a);
      quote(14, 0, 0, "R11 sram");
   endtask

   task automatic t_timing;
      write_cfg(16'h0000);
      access(12, 1, 0, "R8 long");   // 4+1+8=13
      access(0, 0, 0, "R8 zero");
      access(2, 0, 0, "R8 two");
      access(15, 1, 0, "R8 one");
   endtask

   task automatic t_busy_ignore;
      bit ok = 1;
      write_cfg(16'h0000);
      // win0 nseq 16-bit = 4
      @(negedge clk);
      req = 1; req_addr = 32'h0800_0000; req_wide = 0; req_seq = 0;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (k == 1) begin req = 1; req_addr = 32'h0C00_0000; req_wide = 1; end
         else req = 0;
         #1;
         if (ready != (k == 4)) ok = 0;
      end
      check(ok, "R9 request while busy ignored", ok, 1);
   endtask

   task automatic t_cfg_inflight;
      bit ok = 1;
      write_cfg(16'h0000);                 // win2 nseq 16 = 4
      @(negedge clk);
      req = 1; req_addr = 32'h0C00_0000; req_wide = 0; req_seq = 0;
      @(negedge clk);
      req = 0; cfg_we = 1; cfg_wdata = 16'h0300; #1;
      if (ready) ok = 0;
      @(negedge clk);
      cfg_we = 0; shadow = 16'h0300;
      for (int k = 2; k <= 6; k++) begin
         #1;
         if (ready != (k == 4)) ok = 0;
         @(negedge clk);
      end
      check(ok, "R10 in-flight keeps old cost", ok, 1);
      quote(12, 0, 0, "R10 new cost later");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_fields();
      t_mirror_wide();
      t_high_bits();
      t_timing();
      t_busy_ignore();
      t_cfg_inflight();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule